// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of external interrupt sources and delivers them to several interrupt targets, called contexts. A context is one privilege level of one hardware thread. Every source carries a programmable priority. Every context has its own mask of enabled sources and its own priority threshold. While at least one source qualifies for a context, the block raises that context's interrupt line.

Each source enters through a gateway, which is either edge- or level-sensitive depending on a build parameter. The gateway turns the input into a pending bit. Handlers never see which kind of gateway a source uses. Software finds out which source to service by reading a claim register for its context. The read returns the best qualifying source ID, clears that source's pending bit and marks the source as in flight. When software writes the same ID back to the claim register, the source is released.

Configuration and the claim/complete handshake share one register-style port. A 2-bit selector chooses priority, enable, threshold or claim. An index chooses the source or the context. Reads are combinational, and the claim side effect happens on the clock edge of the read strobe.

Top module: `plic_core`

## Requirements
- R1: After reset, all pending and in-flight state is clear and every priority, enable mask and threshold reads 0. Every context line is low and every claim read returns 0.
- R2: The register port works as follows. Selector 0 with index s in 1..N_SRC reads and writes the priority of source s in the low PRIO_W bits. Selector 1 with index c reads and writes the enable mask of context c, where bit s enables source s and bit 0 always reads 0. Selector 2 with index c reads and writes the threshold of context c. Out-of-range indices read 0 and their writes are dropped.
- R3: A source qualifies for context c only when it is pending, enabled for c, and has a priority strictly greater than c's threshold. A priority of 0 therefore never qualifies. The line for context c is high exactly when some source qualifies for c.
- R4: A claim read (selector 3, index c) returns the qualifying source with the highest priority. Ties go to the lowest source ID. The read returns 0 when nothing qualifies.
- R5: A claim read that returns a nonzero ID clears that source's pending bit on the same clock edge and puts the source in flight.
- R6: While a source is in flight, its gateway forwards no new request, so the source qualifies for no context.
- R7: An edge gateway (bit k of EDGE_SRC set for source ID k+1) records one request per low-to-high transition of its input. Several transitions before the claim collapse into one request, and a transition during the in-flight period is lost.
- R8: A level gateway records a request whenever its input is high and the source is neither pending nor in flight. A request stays pending even if the input drops before the claim. After completion, the source becomes pending again if the input is still high.
- R9: A completion write (selector 3, any index, write data = source ID) releases that source only if it is in flight. Any other ID, including 0 and IDs above N_SRC, changes nothing.
- R10: Enables are independent per context. A pending source raises only the lines of contexts that have it enabled and whose threshold it exceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq_i | input | N_SRC | Source inputs; bit k is source ID k+1 |
| ctx_irq_o | output | N_CTX | Interrupt line of each context |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe (claims when selector is 3) |
| reg_sel_i | input | 2 | 0 priority, 1 enable, 2 threshold, 3 claim/complete |
| reg_idx_i | input | IDX_W | Source index (selector 0) or context index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data |

## Verification
The bench targets priority ties, where a design that scans in the wrong direction would hand out the higher ID first. It also probes the threshold boundary at equality, where an inclusive compare would wake a context that should stay quiet. It holds level sources high across claim and completion: a gateway that ignored the in-flight state would re-raise the line at once, and one that forgot to re-arm would lose the interrupt. It sends stray completion IDs, repeated edges and edges during the in-flight period, which catch a design that releases the wrong source or counts each edge as a separate request.

// File: rtl/plic_pkg.sv
package plic_pkg;
   typedef enum logic [1:0] {
      SEL_PRIO   = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_THRESH = 2'd2,
      SEL_CLAIM  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
   parameter bit IS_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic claim_i,
   input  logic complete_i,
   output logic pending_o,
   output logic inflight_o
);
   logic pend_q, infl_q, req;

   generate
      if (IS_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_i;
         end
         assign req = src_i & ~prev_q;
      end else begin : g_level
         assign req = src_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         infl_q <= 1'b0;
      end else begin
         if (claim_i)             pend_q <= 1'b0;
         else if (req && !infl_q) pend_q <= 1'b1;
         if (claim_i)             infl_q <= 1'b1;
         else if (complete_i)     infl_q <= 1'b0;
      end
   end

   assign pending_o  = pend_q;
   assign inflight_o = infl_q;

   assert_claim_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_i |=> !pending_o);
   assert_hold_while_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inflight_o |=> !pending_o);
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
   parameter int N_SRC  = 10,
   parameter int PRIO_W = 3,
   localparam int ID_W  = $clog2(N_SRC + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_SRC:0]               pending_i,
   input  logic [N_SRC:0]               enable_i,
   input  logic [N_SRC:0][PRIO_W-1:0]   prio_i,
   input  logic [PRIO_W-1:0]            thresh_i,
   output logic [ID_W-1:0]              best_id_o,
   output logic                         irq_o
);
   logic [PRIO_W-1:0] best_prio;

   // ascending scan with strict compare keeps the lowest ID on ties
   always_comb begin
      best_id_o = '0;
      best_prio = thresh_i;
      for (int s = 1; s <= N_SRC; s++) begin
         if (pending_i[s] && enable_i[s] && prio_i[s] > best_prio) begin
            best_prio = prio_i[s];
            best_id_o = ID_W'(s);
         end
      end
   end

   assign irq_o = (best_id_o != '0);

   assert_winner_qualifies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pending_i[best_id_o] && enable_i[best_id_o] && prio_i[best_id_o] > thresh_i));
endmodule

// File: rtl/plic_core.sv
module plic_core
   import plic_pkg::*;
#(
   parameter int              N_SRC    = 10,
   parameter int              N_CTX    = 4,
   parameter int              PRIO_W   = 3,
   parameter logic [N_SRC-1:0] EDGE_SRC = N_SRC'(4'b1111),
   localparam int IDX_W = $clog2((N_SRC + 1 > N_CTX) ? N_SRC + 1 : N_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_irq_i,
   output logic [N_CTX-1:0]  ctx_irq_o,
   input  logic              reg_we_i,
   input  logic              reg_re_i,
   input  logic [1:0]        reg_sel_i,
   input  logic [IDX_W-1:0]  reg_idx_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o
);
   localparam int ID_W = $clog2(N_SRC + 1);

   generate
      if (N_SRC < 1 || N_SRC > 31) begin : g_bad_nsrc
         $error("plic_core: N_SRC must lie in 1..31");
      end
      if (N_CTX < 1 || PRIO_W < 1 || PRIO_W > 31) begin : g_bad_shape
         $error("plic_core: N_CTX and PRIO_W out of range");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel_i);

   logic [N_SRC:0][PRIO_W-1:0]  prio_q;
   logic [N_CTX-1:0][N_SRC:0]   en_q;
   logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
   logic [N_SRC:0]              pend, infl, claim_vec, done_vec;
   logic [N_CTX-1:0][ID_W-1:0]  best;
   logic [ID_W-1:0]             claim_id;
   logic                        claim_fire;

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
      end else if (reg_we_i) begin
         for (int s = 1; s <= N_SRC; s++)
            if (sel == SEL_PRIO && reg_idx_i == IDX_W'(s))
               prio_q[s] <= reg_wdata_i[PRIO_W-1:0];
         for (int c = 0; c < N_CTX; c++) begin
            if (sel == SEL_ENABLE && reg_idx_i == IDX_W'(c))
               en_q[c] <= {reg_wdata_i[N_SRC:1], 1'b0};
            if (sel == SEL_THRESH && reg_idx_i == IDX_W'(c))
               thr_q[c] <= reg_wdata_i[PRIO_W-1:0];
         end
      end
   end

   // claim / complete decode
   always_comb begin
      claim_id = '0;
      for (int c = 0; c < N_CTX; c++)
         if (reg_idx_i == IDX_W'(c)) claim_id = best[c];
   end
   assign claim_fire = reg_re_i && (sel == SEL_CLAIM) && (claim_id != '0);

   always_comb begin
      claim_vec[0] = 1'b0;
      done_vec[0]  = 1'b0;
      for (int s = 1; s <= N_SRC; s++) begin
         claim_vec[s] = claim_fire && (claim_id == ID_W'(s));
         done_vec[s]  = reg_we_i && (sel == SEL_CLAIM) && (reg_wdata_i == 32'(s));
      end
   end

   // gateways, one per source, variant chosen per source
   assign pend[0] = 1'b0;
   assign infl[0] = 1'b0;
   generate
      for (genvar s = 1; s <= N_SRC; s++) begin : g_gw
         plic_gateway #(.IS_EDGE(EDGE_SRC[s-1])) u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_irq_i[s-1]),
            .claim_i    (claim_vec[s]),
            .complete_i (done_vec[s]),
            .pending_o  (pend[s]),
            .inflight_o (infl[s])
         );
      end
      for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
         plic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .pending_i (pend),
            .enable_i  (en_q[c]),
            .prio_i    (prio_q),
            .thresh_i  (thr_q[c]),
            .best_id_o (best[c]),
            .irq_o     (ctx_irq_o[c])
         );
      end
   endgenerate

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      unique case (sel)
         SEL_PRIO: for (int s = 1; s <= N_SRC; s++)
            if (reg_idx_i == IDX_W'(s)) reg_rdata_o = 32'(prio_q[s]);
         SEL_ENABLE: for (int c = 0; c < N_CTX; c++)
            if (reg_idx_i == IDX_W'(c)) reg_rdata_o = 32'(en_q[c]);
         SEL_THRESH: for (int c = 0; c < N_CTX; c++)
            if (reg_idx_i == IDX_W'(c)) reg_rdata_o = 32'(thr_q[c]);
         SEL_CLAIM: reg_rdata_o = 32'(claim_id);
         default: reg_rdata_o = '0;
      endcase
   end

   assert_claim_marks_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_fire |=> ((infl & $past(claim_vec)) == $past(claim_vec)));
   assert_stray_complete_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && sel == SEL_CLAIM && !claim_fire && ((done_vec & infl) == '0)) |=> $stable(infl));
endmodule

// File: tb/plic_core_tb.sv
`timescale 1ns/1ps
module plic_core_tb_top;
   localparam int NS = 10;
   localparam int NC = 4;
   localparam int PW = 3;
   localparam int IW = 4;
   localparam logic [NS-1:0] EDGES = 10'b00_0000_1111;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_irq = '0;
   logic [NC-1:0] ctx_irq;
   logic          we = 1'b0, re = 1'b0;
   logic [1:0]    sel = '0;
   logic [IW-1:0] idx = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;

   always #4 clk = ~clk;

   plic_core #(.N_SRC(NS), .N_CTX(NC), .PRIO_W(PW), .EDGE_SRC(EDGES)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_irq_i(src_irq), .ctx_irq_o(ctx_irq),
      .reg_we_i(we), .reg_re_i(re), .reg_sel_i(sel), .reg_idx_i(idx),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata));

   // behavioural reference state
   int    m_prio [NS+1];
   bit    m_en   [NC][NS+1];
   int    m_thr  [NC];
   bit    m_pend [NS+1];
   bit    m_infl [NS+1];
   bit    m_prev [NS+1];
   int    checks = 0, fails = 0;
   string tag = "R1";
   bit    done = 1'b0;

   function automatic int best_of(int c);
      int b = 0, bp = m_thr[c];
      for (int s = 1; s <= NS; s++)
         if (m_pend[s] && m_en[c][s] && m_prio[s] > bp) begin bp = m_prio[s]; b = s; end
      return b;
   endfunction

   function automatic int exp_read(int sl, int ix);
      int v = 0;
      case (sl)
         0: if (ix >= 1 && ix <= NS) v = m_prio[ix];
         1: if (ix < NC) for (int s = 1; s <= NS; s++) if (m_en[ix][s]) v |= (1 << s);
         2: if (ix < NC) v = m_thr[ix];
         default: if (ix < NC) v = best_of(ix);
      endcase
      return v;
   endfunction

   task automatic check(string t, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s <= NS; s++) begin
         m_prio[s] = 0; m_pend[s] = 0; m_infl[s] = 0; m_prev[s] = 0;
         for (int c = 0; c < NC; c++) m_en[c][s] = 0;
      end
      for (int c = 0; c < NC; c++) m_thr[c] = 0;
   endtask

   // one clock: compare, predict, advance
   task automatic cycle();
      int ix, sl, cid, wd;
      int n_prio [NS+1];
      bit n_en [NC][NS+1];
      int n_thr [NC];
      bit n_pend [NS+1];
      bit n_infl [NS+1];
      bit n_prev [NS+1];
      #1;
      ix = int'(idx); sl = int'(sel); wd = int'(wdata);
      for (int c = 0; c < NC; c++) check(tag, int'(ctx_irq[c]), int'(best_of(c) != 0));
      if (re) check(tag, int'(rdata), exp_read(sl, ix));
      n_prio = m_prio; n_en = m_en; n_thr = m_thr;
      cid = (re && sl == 3 && ix < NC) ? best_of(ix) : 0;
      if (we) begin
         if (sl == 0 && ix >= 1 && ix <= NS) n_prio[ix] = wd & ((1 << PW) - 1);
         if (sl == 1 && ix < NC) for (int s = 1; s <= NS; s++) n_en[ix][s] = wd[s];
         if (sl == 2 && ix < NC) n_thr[ix] = wd & ((1 << PW) - 1);
      end
      for (int s = 1; s <= NS; s++) begin
         bit in = src_irq[s-1];
         bit rq = EDGES[s-1] ? (in && !m_prev[s]) : in;
         n_prev[s] = in;
         n_pend[s] = (cid == s) ? 1'b0 : ((rq && !m_infl[s]) ? 1'b1 : m_pend[s]);
         if (cid == s) n_infl[s] = 1'b1;
         else if (we && sl == 3 && wd == s) n_infl[s] = 1'b0;
         else n_infl[s] = m_infl[s];
      end
      @(posedge clk);
      m_prio = n_prio; m_en = n_en; m_thr = n_thr;
      for (int s = 1; s <= NS; s++) begin
         m_pend[s] = n_pend[s]; m_infl[s] = n_infl[s]; m_prev[s] = n_prev[s];
      end
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask
   task automatic wr(int sl, int ix, int d);
      we = 1'b1; sel = 2'(sl); idx = IW'(ix); wdata = 32'(d);
      cycle();
      we = 1'b0;
   endtask
   task automatic rd(int sl, int ix);
      re = 1'b1; sel = 2'(sl); idx = IW'(ix);
      cycle();
      re = 1'b0;
   endtask
   task automatic drive(int id, bit v);
      src_irq[id-1] = v;
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      tag = "R1";
      for (int c = 0; c < NC; c++) begin rd(3, c); rd(1, c); rd(2, c); end
      rd(0, 4);
      // R2 configuration access
      tag = "R2";
      wr(0, 1, 2); wr(0, 2, 5); wr(0, 3, 5); wr(0, 4, 1); wr(0, 5, 3);
      wr(0, 6, 7); wr(0, 7, 0); wr(0, 8, 4); wr(0, 9, 6); wr(0, 10, 2);
      wr(0, 0, 7); wr(0, 11, 5); wr(0, 6, 32'hFF);
      for (int s = 0; s <= 11; s++) rd(0, s);
      wr(1, 0, 32'h7FF); wr(1, 1, 32'h060); wr(1, 2, 32'h7FE); wr(1, 3, 0);
      wr(2, 2, 5); wr(2, 9, 3);
      for (int c = 0; c < 5; c++) begin rd(1, c); rd(2, c); end
      // R10 level source 6 (prio 7) reaches only enabled contexts
      tag = "R10";
      drive(6, 1); idle(2);
      // R5 claim on ctx1 hides it from all contexts
      tag = "R5";
      rd(3, 1); idle(1);
      // R6 still held high while in flight
      tag = "R6";
      idle(3); rd(3, 0);
      // R8 completion re-arms a still-high level source
      tag = "R8";
      wr(3, 3, 6); idle(2); drive(6, 0); idle(2); rd(3, 0); wr(3, 0, 6); idle(2); rd(3, 0);
      // R9 stray completions while source 5 is in flight
      tag = "R9";
      drive(5, 1); idle(1); rd(3, 0);
      wr(3, 0, 9); wr(3, 0, 0); wr(3, 1, 20); wr(3, 0, 15); idle(2); rd(3, 1);
      drive(5, 0); wr(3, 0, 5); idle(2); rd(3, 0);
      // R4 equal priorities, then higher priority wins
      tag = "R4";
      drive(2, 1); drive(3, 1); idle(1); drive(2, 0); drive(3, 0); idle(1);
      rd(3, 0); rd(3, 0); rd(3, 0); wr(3, 0, 2); wr(3, 0, 3);
      drive(1, 1); drive(8, 1); idle(1); drive(1, 0); drive(8, 0);
      rd(3, 0); rd(3, 0); wr(3, 0, 8); wr(3, 0, 1); rd(3, 0);
      // R3 threshold equality and priority zero
      tag = "R3";
      drive(7, 1); drive(9, 1); drive(3, 1); idle(2); rd(3, 2);
      wr(2, 2, 6); idle(1); rd(3, 2); wr(2, 2, 5);
      rd(3, 0); rd(3, 0); rd(3, 0);
      drive(7, 0); drive(9, 0); drive(3, 0); wr(3, 0, 9); wr(3, 0, 3); idle(2);
      // R7 edge gateway: held input, repeated edges, edge in flight
      tag = "R7";
      drive(1, 1); idle(4); rd(3, 0); wr(3, 0, 1); idle(3); rd(3, 0);
      drive(1, 0); idle(1); drive(1, 1); idle(1); drive(1, 0); idle(1); drive(1, 1); idle(1);
      rd(3, 0); rd(3, 0);
      drive(1, 0); idle(1); drive(1, 1); idle(1); drive(1, 0);
      wr(3, 0, 1); idle(2); rd(3, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule